// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level translation structure held in ordinary memory. The linear address is cut into three fields: the top ten bits select a word in the page directory, the next ten bits select a word in the page table that the directory word points at, and the low twelve bits pass straight through as the byte offset inside the 4 KiB frame named by the table word. The directory itself starts at a 4 KiB-aligned address taken from the `dir_base` input.

Each request carries the linear address, a write flag and a user flag. The walker reads both entries over a simple request/ready memory port and checks presence and access rights at each level. If both levels pass, it writes back any entry whose accessed or dirty flag has to change, and then reports the physical address. If a check fails, it reports a two-bit fault cause and leaves memory untouched. Completion is a one-cycle `done` pulse. A new request is taken only while the walker is idle.

Top module: `pgwalk`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` has no effect while a walk is in progress, and every accepted request produces exactly one `done` pulse.
- R2: The first read of a walk goes to `{dir_base[31:12], 12'h000} + 4 * vaddr[31:22]`. The low 12 bits of `dir_base` are ignored.
- R3: If the directory word passes its checks, the second read goes to `{pde[31:12], 12'h000} + 4 * vaddr[21:12]`. If it fails, no second read is made.
- R4: A successful walk reports `fault_cause` 2'b00 and `paddr = {pte[31:12], vaddr[11:0]}`.
- R5: An entry whose bit 0 (present) is 0 ends the walk with `fault_cause` 2'b01, whatever its other 31 bits hold. The directory word is checked before the table word.
- R6: For a user request (`req_user`=1), bit 2 equal to 0 in either entry gives `fault_cause` 2'b10. A user write to an entry whose bit 1 is 0 also gives 2'b10. A supervisor request ignores bits 1 and 2. A user read is allowed when bit 1 is 0.
- R7: After a successful walk, bit 5 (accessed) is set in both the directory word and the table word in memory.
- R8: After a successful write walk, bit 6 (dirty) is set in the table word. The walker never changes bit 6 of a directory word, and never sets it on a read walk.
- R9: Write-back leaves every other bit unchanged, including software bits 11:9. A word is written only if its bit 5 or bit 6 actually changes. Writes happen only after both reads, with the directory word first. A faulting walk writes nothing.
- R10: `done` is high for exactly one cycle per walk. `fault_cause` and `paddr` are valid while it is high.
- R11: A memory request keeps `mem_addr` and `mem_we` stable until `mem_ready` is seen high. Every access is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user level |
| dir_base | input | 32 | Directory base address (low 12 bits ignored) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Memory accepts or completes the access |
| done | output | 1 | One-cycle completion pulse |
| fault_cause | output | 2 | 00 ok, 01 not present, 10 protection |
| paddr | output | 32 | Physical address (zero on fault) |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the permission check and the decision to write back. The table word arrives on the same edge where both its fault check runs and the choice is made between writing the directory word, writing the table word, or finishing. Vectors that fault only at the table level are therefore compared against memory afterwards, to prove that the directory word kept its accessed bit clear. The second pair is the request strobe and a busy walk. `req_valid` is held high with a different address while the walker is reading under added memory latency, and the bench expects one `done` pulse that carries the translation of the first address only.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;

   // Entry flag positions; the walker and the tables in memory share them.
   localparam int unsigned PG_P  = 0;
   localparam int unsigned PG_RW = 1;
   localparam int unsigned PG_US = 2;
   localparam int unsigned PG_A  = 5;
   localparam int unsigned PG_D  = 6;

   typedef enum logic [1:0] {
      CZ_NONE   = 2'b00,
      CZ_ABSENT = 2'b01,
      CZ_PROT   = 2'b10
   } cause_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RDIR,
      S_RTBL,
      S_WDIR,
      S_WTBL,
      S_FIN
   } walk_st_e;

   // flg = {us, rw, p}: true when the access may use this entry
   function automatic logic pg_allow(input logic [2:0] flg,
                                     input logic       user,
                                     input logic       wr);
      return !user || (flg[2] && (!wr || flg[1]));
   endfunction

endpackage

// File: rtl/pgwalk_agen.sv
`timescale 1ns/1ps
module pgwalk_agen #(
   parameter int unsigned AW       = 32,
   parameter int unsigned DIR_BITS = 10,
   parameter int unsigned TBL_BITS = 10,
   parameter int unsigned OFF_BITS = 12
) (
   input  logic [AW-1:0]          vaddr,
   input  logic [AW-OFF_BITS-1:0] base_frame,
   input  logic [AW-OFF_BITS-1:0] pde_frame,
   input  logic [AW-OFF_BITS-1:0] pte_frame,
   output logic [AW-1:0]          dir_ea,
   output logic [AW-1:0]          tbl_ea,
   output logic [AW-1:0]          pa
);
   localparam int unsigned IX_SH = 2;   // four bytes per entry

   if (DIR_BITS + TBL_BITS + OFF_BITS != AW) begin : g_bad_split
      $error("pgwalk_agen: index and offset widths must sum to AW");
   end
   if (DIR_BITS + IX_SH > OFF_BITS || TBL_BITS + IX_SH > OFF_BITS) begin : g_bad_fit
      $error("pgwalk_agen: an index table must fit inside one frame");
   end

   logic [DIR_BITS-1:0] dir_idx;
   logic [TBL_BITS-1:0] tbl_idx;

   assign dir_idx = vaddr[AW-1 -: DIR_BITS];
   assign tbl_idx = vaddr[OFF_BITS +: TBL_BITS];

   assign dir_ea = {base_frame, {OFF_BITS{1'b0}}} + AW'({dir_idx, {IX_SH{1'b0}}});
   assign tbl_ea = {pde_frame,  {OFF_BITS{1'b0}}} + AW'({tbl_idx, {IX_SH{1'b0}}});
   assign pa     = {pte_frame, vaddr[OFF_BITS-1:0]};

endmodule

// File: rtl/pgwalk_upd.sv
`timescale 1ns/1ps
module pgwalk_upd
   import pgwalk_pkg::*;
#(
   parameter int unsigned EW   = 32,
   parameter bit          LEAF = 1'b0
) (
   input  logic [EW-1:0] ent,
   input  logic          wr,
   output logic [EW-1:0] nxt,
   output logic          chg
);
   if (EW <= PG_D) begin : g_bad_width
      $error("pgwalk_upd: entry too narrow for its flags");
   end

   localparam logic [EW-1:0] A_M = EW'(1) << PG_A;
   localparam logic [EW-1:0] D_M = EW'(1) << PG_D;

   logic [EW-1:0] set_m;

   if (LEAF) begin : g_leaf
      assign set_m = A_M | (wr ? D_M : '0);
   end else begin : g_node
      logic unused_wr;
      assign unused_wr = wr;
      assign set_m     = A_M;
   end

   assign nxt = ent | set_m;
   assign chg = (nxt != ent);

endmodule

// File: rtl/pgwalk.sv
`timescale 1ns/1ps
module pgwalk
   import pgwalk_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DIR_BITS = 10,
   parameter int unsigned TBL_BITS = 10,
   parameter int unsigned OFF_BITS = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_vaddr,
   input  logic          req_write,
   input  logic          req_user,
   input  logic [AW-1:0] dir_base,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] mem_wdata,
   input  logic [AW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic          done,
   output logic [1:0]    fault_cause,
   output logic [AW-1:0] paddr
);
   localparam int unsigned LEVELS = 2;
   localparam int unsigned FW     = AW - OFF_BITS;

   if (AW != 32) begin : g_bad_aw
      $error("pgwalk: entry layout assumes 32-bit words");
   end

   walk_st_e      st;
   cause_e        cause_q;
   logic [AW-1:0] va_q, pde_q, pte_q;
   logic          wr_q, usr_q;

   logic [AW-1:0] dir_ea, tbl_ea, pa;
   logic [AW-1:0] lvl_ent [LEVELS];
   logic [AW-1:0] lvl_nxt [LEVELS];
   logic          lvl_chg [LEVELS];
   logic          rd_present, rd_allow;
   logic          unused_base;

   assign unused_base = ^dir_base[OFF_BITS-1:0];

   pgwalk_agen #(
      .AW(AW), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS), .OFF_BITS(OFF_BITS)
   ) u_agen (
      .vaddr     (va_q),
      .base_frame(dir_base[AW-1:OFF_BITS]),
      .pde_frame (pde_q[AW-1:OFF_BITS]),
      .pte_frame (pte_q[AW-1:OFF_BITS]),
      .dir_ea    (dir_ea),
      .tbl_ea    (tbl_ea),
      .pa        (pa)
   );

   assign lvl_ent[0] = pde_q;
   assign lvl_ent[1] = pte_q;

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      pgwalk_upd #(.EW(AW), .LEAF(g == LEVELS-1)) u_upd (
         .ent(lvl_ent[g]),
         .wr (wr_q),
         .nxt(lvl_nxt[g]),
         .chg(lvl_chg[g])
      );
   end

   // checks run on the word as it returns from memory
   assign rd_present = mem_rdata[PG_P];
   assign rd_allow   = pg_allow(mem_rdata[2:0], usr_q, wr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cause_q <= CZ_NONE;
         va_q    <= '0;
         pde_q   <= '0;
         pte_q   <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               usr_q   <= req_user;
               cause_q <= CZ_NONE;
               st      <= S_RDIR;
            end
            S_RDIR: if (mem_ready) begin
               pde_q <= mem_rdata;
               if (!rd_present) begin
                  cause_q <= CZ_ABSENT;
                  st      <= S_FIN;
               end else if (!rd_allow) begin
                  cause_q <= CZ_PROT;
                  st      <= S_FIN;
               end else begin
                  st <= S_RTBL;
               end
            end
            S_RTBL: if (mem_ready) begin
               pte_q <= mem_rdata;
               if (!rd_present) begin
                  cause_q <= CZ_ABSENT;
                  st      <= S_FIN;
               end else if (!rd_allow) begin
                  cause_q <= CZ_PROT;
                  st      <= S_FIN;
               end else begin
                  st <= lvl_chg[0] ? S_WDIR : S_WTBL;
               end
            end
            S_WDIR: if (mem_ready) st <= S_WTBL;
            S_WTBL: if (!lvl_chg[1] || mem_ready) st <= S_FIN;
            S_FIN:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (st == S_IDLE);
   assign mem_req     = (st == S_RDIR) || (st == S_RTBL) || (st == S_WDIR) ||
                        ((st == S_WTBL) && lvl_chg[1]);
   assign mem_we      = (st == S_WDIR) || (st == S_WTBL);
   assign mem_addr    = ((st == S_RDIR) || (st == S_WDIR)) ? dir_ea : tbl_ea;
   assign mem_wdata   = (st == S_WDIR) ? lvl_nxt[0] : lvl_nxt[1];
   assign done        = (st == S_FIN);
   assign fault_cause = cause_q;
   assign paddr       = (cause_q == CZ_NONE) ? pa : '0;

   // R1: a taken request makes the walker busy
   a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R11: request held steady until the memory answers
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R11: word aligned accesses
   a_r11_align: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R7: every write-back carries the accessed flag
   a_r7_abit: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[PG_A]);

   // R8: directory dirty flag never altered
   a_r8_dir_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == S_WDIR) |-> (mem_wdata[PG_D] == pde_q[PG_D]));

   // R9: table write keeps every bit but the two flags
   a_r9_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == S_WTBL) |->
         ((mem_wdata | 32'h60) == (pte_q | 32'h60)));

   // R9: no write on a faulting walk
   a_r9_no_fault_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (cause_q == CZ_NONE));

   // R10: done lasts one cycle
   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: cause code always legal at completion
   a_r5_legal_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault_cause != 2'b11));

endmodule

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid, req_ready, req_write, req_user;
   logic [31:0] req_vaddr, dir_base;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        done;
   logic [1:0]  fault_cause;
   logic [31:0] paddr;

   always #2.5 clk = ~clk;

   pgwalk uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
      .dir_base(dir_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .done(done), .fault_cause(fault_cause), .paddr(paddr)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [0:4095];
   logic        clr;
   int          lat, cnt;
   int          rd_n, wr_n, hold_err, bad;
   logic [31:0] rd_log [4];
   logic [31:0] wr_log [4];
   logic        pend;
   logic [31:0] pend_addr;

   initial begin
      cnt = 0; rd_n = 0; wr_n = 0; hold_err = 0; bad = 0; pend = 1'b0; pend_addr = '0;
   end

   assign mem_ready = mem_req && (cnt == lat);
   assign mem_rdata = mem[mem_addr[13:2]];

   always @(posedge clk) begin
      if (mem_req && !mem_ready) cnt <= cnt + 1;
      else                       cnt <= 0;
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_err <= hold_err + 1;
      pend      <= mem_req && !mem_ready;
      pend_addr <= mem_addr;
      if (mem_req && mem_addr >= 32'h4000) bad <= bad + 1;
      if (clr) begin
         rd_n <= 0;
         wr_n <= 0;
      end else if (mem_req && mem_ready) begin
         if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            if (wr_n < 4) wr_log[wr_n] <= mem_addr;
            wr_n <= wr_n + 1;
         end else begin
            if (rd_n < 4) rd_log[rd_n] <= mem_addr;
            rd_n <= rd_n + 1;
         end
      end
   end

   // ---------------- checking ----------------
   int nchk = 0;
   int nerr = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                       output logic [1:0] cz, output logic [31:0] pa);
      logic got;
      @(negedge clk);
      clr = 1'b1; req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
      @(negedge clk);
      clr = 1'b0; req_valid = 1'b0;
      got = 1'b0; cz = 2'b11; pa = '0;
      for (int k = 0; k < 60 && !got; k++) begin
         @(negedge clk);
         if (done) begin
            got = 1'b1; cz = fault_cause; pa = paddr;
         end
      end
      chk("R10 done seen", {31'd0, got}, 32'd1);
      @(negedge clk);
      chk("R10 done one cycle", {31'd0, done}, 32'd0);
   endtask

   // ---------------- vectors ----------------
   typedef struct packed {
      logic [31:0] va;
      logic        wr;
      logic        usr;
      logic [31:0] pde;
      logic [31:0] pte;
      logic [31:0] pde_x;
      logic [31:0] pte_x;
      logic [31:0] pa_x;
      logic [1:0]  cz_x;
      logic [1:0]  nwr_x;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{32'h0040_5123, 1'b0, 1'b0, 32'h0000_2007, 32'h0ABC_D003, 32'h0000_2027, 32'h0ABC_D023, 32'h0ABC_D123, 2'b00, 2'd2},
      '{32'h0080_7FFF, 1'b1, 1'b1, 32'h0000_2007, 32'h1234_5E07, 32'h0000_2027, 32'h1234_5E67, 32'h1234_5FFF, 2'b00, 2'd2},
      '{32'h00C0_1000, 1'b0, 1'b1, 32'h0000_2006, 32'h0000_0007, 32'h0000_2006, 32'h0000_0007, 32'h0000_0000, 2'b01, 2'd0},
      '{32'h0100_2004, 1'b0, 1'b1, 32'h0000_2027, 32'hFFFF_FFFE, 32'h0000_2027, 32'hFFFF_FFFE, 32'h0000_0000, 2'b01, 2'd0},
      '{32'h0140_3000, 1'b0, 1'b1, 32'h0000_2003, 32'h5000_0007, 32'h0000_2003, 32'h5000_0007, 32'h0000_0000, 2'b10, 2'd0},
      '{32'h0180_4000, 1'b0, 1'b1, 32'h0000_2007, 32'h5000_0003, 32'h0000_2007, 32'h5000_0003, 32'h0000_0000, 2'b10, 2'd0},
      '{32'h01C0_5000, 1'b1, 1'b1, 32'h0000_2005, 32'h5000_0007, 32'h0000_2005, 32'h5000_0007, 32'h0000_0000, 2'b10, 2'd0},
      '{32'h0200_6ABC, 1'b0, 1'b1, 32'h0000_2005, 32'h6000_0005, 32'h0000_2025, 32'h6000_0025, 32'h6000_0ABC, 2'b00, 2'd2},
      '{32'h0240_7010, 1'b1, 1'b0, 32'h0000_2001, 32'h7000_0001, 32'h0000_2021, 32'h7000_0061, 32'h7000_0010, 2'b00, 2'd2},
      '{32'h0280_8004, 1'b1, 1'b1, 32'h0000_2027, 32'h8000_0067, 32'h0000_2027, 32'h8000_0067, 32'h8000_0004, 2'b00, 2'd0},
      '{32'h02C0_9008, 1'b0, 1'b1, 32'h0000_2027, 32'h9000_0047, 32'h0000_2027, 32'h9000_0067, 32'h9000_0008, 2'b00, 2'd1},
      '{32'h0300_A000, 1'b1, 1'b1, 32'h0000_2007, 32'h9100_0005, 32'h0000_2007, 32'h9100_0005, 32'h0000_0000, 2'b10, 2'd0}
   };

   // watchdog: 200,000 cycles of 5 ns
   initial begin
      #1000000;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [1:0]  cz;
      logic [31:0] pa;
      int          ndone;

      req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
      dir_base = 32'h0000_1000; clr = 1'b0; lat = 0;
      for (int i = 0; i < 4096; i++) mem[i] = '0;

      repeat (3) @(negedge clk);
      chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
      chk("R10 reset done", {31'd0, done}, 32'd0);
      chk("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;

      // table-driven walks
      for (int i = 0; i < NV; i++) begin
         vec_t        v;
         logic [9:0]  di, ti;
         logic        dpass;
         string       ctag;
         v  = VEC[i];
         di = v.va[31:22];
         ti = v.va[21:12];
         lat = i % 3;
         mem[1024 + int'(di)] = v.pde;
         mem[2048 + int'(ti)] = v.pte;
         dpass = v.pde[0] && (!v.usr || (v.pde[2] && (!v.wr || v.pde[1])));
         walk(v.va, v.wr, v.usr, cz, pa);
         ctag = (v.cz_x == 2'b01) ? "R5 cause" : (v.cz_x == 2'b10) ? "R6 cause" : "R4 cause";
         chk(ctag, {30'd0, cz}, {30'd0, v.cz_x});
         chk("R4 paddr", pa, v.pa_x);
         chk("R2 dir entry addr", rd_log[0], 32'h1000 + {20'd0, di, 2'b00});
         chk("R3 read count", rd_n, dpass ? 2 : 1);
         if (dpass) chk("R3 table entry addr", rd_log[1], 32'h2000 + {20'd0, ti, 2'b00});
         chk("R7 directory word after", mem[1024 + int'(di)], v.pde_x);
         chk("R8 table word after", mem[2048 + int'(ti)], v.pte_x);
         chk("R9 write count", wr_n, {30'd0, v.nwr_x});
         if (v.nwr_x == 2'd2) chk("R9 directory written first", wr_log[0], 32'h1000 + {20'd0, di, 2'b00});
      end

      // R2: low bits of the base are ignored
      lat = 1;
      dir_base = 32'h0000_1ABC;
      mem[1024 + 1] = 32'h0000_2027;
      mem[2048 + 0] = 32'h3000_0067;
      walk(32'h0040_0010, 1'b0, 1'b0, cz, pa);
      chk("R2 base low bits ignored", rd_log[0], 32'h0000_1004);
      chk("R4 paddr with odd base", pa, 32'h3000_0010);
      dir_base = 32'h0000_1000;

      // R1: req_valid while busy is ignored
      lat = 2;
      mem[1024 + 13] = 32'h0000_2027;
      mem[2048 + 11] = 32'h4400_0067;
      @(negedge clk);
      clr = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0340_B044; req_write = 1'b0; req_user = 1'b1;
      @(negedge clk);
      clr = 1'b0; req_vaddr = 32'h0380_C000;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      ndone = 0; cz = 2'b11; pa = '0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done) begin
            ndone++; cz = fault_cause; pa = paddr;
         end
      end
      chk("R1 one done per request", ndone, 1);
      chk("R1 busy request ignored cause", {30'd0, cz}, 32'd0);
      chk("R1 busy request ignored paddr", pa, 32'h4400_0044);
      chk("R1 busy request ignored reads", rd_n, 2);

      chk("R11 address held while waiting", hold_err, 0);
      chk("R11 accesses in range", bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule